// File: doc/BRIEF.md
# Breakpoint Value Register Bank with Debug Access Gate

This block holds the comparison values for a set of hardware breakpoints, each 64 bits wide. It sits behind a memory-mapped debug port and serves 32-bit accesses to those registers. Each access is decoded from a byte offset. The block checks the core power and lock flags for every access. It then returns read data, performs the write, or raises an error. Framing of the bus transfer is left to the port logic in front of it. The comparators that consume the stored values are also outside this block.

A request is presented for one cycle. The decision is combinational in that cycle:
- the read word appears on `rdata_o`;
- the error flag appears on `err_o`;
- an accepted write updates the addressed half at the next rising clock edge.

The block is built with a parameter for the number of implemented breakpoints, from 2 to 16. Index slots above that count exist in the address map but hold nothing. The bits above the highest address bit form a sign-extension field. A parameter chooses how that field behaves: it can store whatever software writes, or it can read back as a hardwired copy of the highest address bit.

Top module: `dbg_bkpt_bank`

## Requirements
- R1: Breakpoint n lives at byte offset 0x400 + 16·n, for n from 0 to 15. Its low word (bits 31:0) is at +0 and its high word (bits 63:32) is at +4. Any other address is not claimed. That covers offsets +8 and +C, addresses with bits [1:0] non-zero, and addresses outside 0x400–0x4FF. An unclaimed access reads zero, raises no error and changes nothing. With `req_i` low, `rdata_o` is zero and `err_o` is low.
- R2: The access is open when all four of these hold: `core_pwr_i` is 1, `dlock_i` is 0, `oslock_i` is 0 and `dbg_en_i` is 1. An open access with `sw_lock_i` at 0 may write, and the value takes effect at the next clock edge. An open read returns the stored word. A write request always returns zero on `rdata_o`.
- R3: When the access is open but `sw_lock_i` is 1, reads work normally, writes are discarded and no error is raised.
- R4: When the access is not open, any claimed access sets `err_o` and returns zero data. The register is not modified. This applies to implemented and unimplemented indices alike.
- R5: An open access to an index at or above `NUM_BP` reads zero, discards writes and raises no error.
- R6: Bits [1:0] of every value register read as zero, whatever was written to them.
- R7: With `KEEP_EXT` = 1, the high word stores all 32 written bits and reads them back unchanged.
- R8: With `KEEP_EXT` = 0, bits 63:`VA_MSB`+1 ignore writes. They read as copies of bit `VA_MSB`, which is bit 20 of the high word for the default `VA_MSB` = 52.
- R9: After reset every register reads zero in both halves.
- R10: A write to one half of a register leaves the other half, and every other register, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request valid this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| core_pwr_i | input | 1 | Core power domain is up |
| dlock_i | input | 1 | Double lock is set |
| oslock_i | input | 1 | OS lock is set |
| dbg_en_i | input | 1 | External debug access is permitted |
| sw_lock_i | input | 1 | Software lock is set (read-only access) |
| rdata_o | output | 32 | Read data, zero unless an open read of an implemented slot |
| err_o | output | 1 | Error response for a claimed access with access not open |

## Verification
The bank has no state outside its value registers. A wrong write enable therefore stays invisible until the affected half is next read. Such a fault includes:
- a write that gets through the software lock or an error;
- a write that lands in the wrong slot or half;
- a write that reaches an unimplemented index.

The bench therefore follows each class of blocked write with a read-back of that slot. It also mixes reads into a long pseudo-random stretch, so that a corrupted word shows up within a few requests. Decode and gating faults show up in the same cycle as the request, on `err_o` or `rdata_o`. Faults in the sign-extension field appear only on high-word reads. So two instances with opposite `KEEP_EXT` settings run the same stimulus.

// File: rtl/bpv_pkg.sv
package bpv_pkg;
  localparam int unsigned MAX_BP = 16;
  localparam int unsigned IDX_W  = $clog2(MAX_BP);
  localparam int unsigned DW     = 32;

  typedef struct packed {
    logic             claim;  // address hits a value-register word
    logic             open;   // power and lock conditions pass
    logic             impl;   // index below NUM_BP
    logic             hi;     // upper word selected
    logic [IDX_W-1:0] idx;
  } acc_t;
endpackage

// File: rtl/bpv_decode.sv
module bpv_decode
  import bpv_pkg::*;
#(
  parameter int unsigned      ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE  = 12'h400,
  parameter int unsigned      NUM_BP = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              core_pwr_i,
  input  logic              dlock_i,
  input  logic              oslock_i,
  input  logic              dbg_en_i,
  output acc_t              acc_o
);
  localparam int unsigned WIN_LSB = IDX_W + 4;  // 16 bytes per slot
  localparam logic [ADDR_W-WIN_LSB-1:0] BASE_TAG = BASE[ADDR_W-1:WIN_LSB];
  localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_BP);

  logic [IDX_W-1:0] idx;
  logic             unused_base;

  assign idx         = addr_i[WIN_LSB-1:4];
  assign unused_base = ^BASE[WIN_LSB-1:0];

  always_comb begin
    acc_o       = '0;
    acc_o.claim = (addr_i[ADDR_W-1:WIN_LSB] == BASE_TAG) && !addr_i[3] && (addr_i[1:0] == 2'b00);
    acc_o.open  = core_pwr_i && !dlock_i && !oslock_i && dbg_en_i;
    acc_o.impl  = ({1'b0, idx} < NUM_L);
    acc_o.hi    = addr_i[2];
    acc_o.idx   = idx;
  end
endmodule

// File: rtl/bpv_slot.sv
module bpv_slot
  import bpv_pkg::*;
#(
  parameter int unsigned VA_MSB   = 52,
  parameter bit          KEEP_EXT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_lo_o,
  output logic [DW-1:0] rd_hi_o
);
  localparam int unsigned HI_W  = VA_MSB - DW + 1;
  localparam int unsigned EXT_W = DW - HI_W;

  logic [DW-3:0] lo_q;
  logic          unused_lo;

  assign unused_lo = ^wdata_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lo_q <= '0;
    else if (wr_lo_i) lo_q <= wdata_i[DW-1:2];
  end

  assign rd_lo_o = {lo_q, 2'b00};

  if (KEEP_EXT) begin : g_stored_ext
    logic [DW-1:0] hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hi_q <= '0;
      else if (wr_hi_i) hi_q <= wdata_i;
    end
    assign rd_hi_o = hi_q;
  end else begin : g_mirror_ext
    logic [HI_W-1:0] hi_q;
    logic            unused_ext;
    assign unused_ext = ^wdata_i[DW-1:HI_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hi_q <= '0;
      else if (wr_hi_i) hi_q <= wdata_i[HI_W-1:0];
    end
    assign rd_hi_o = {{EXT_W{hi_q[HI_W-1]}}, hi_q};
  end
endmodule

// File: rtl/bpv_rdmux.sv
module bpv_rdmux
  import bpv_pkg::*;
#(
  parameter int unsigned NUM_BP = 16
) (
  input  logic [NUM_BP-1:0][DW-1:0] lo_i,
  input  logic [NUM_BP-1:0][DW-1:0] hi_i,
  input  logic                      en_i,
  input  logic                      hi_sel_i,
  input  logic [IDX_W-1:0]          idx_i,
  output logic [DW-1:0]             rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < NUM_BP; n++) begin
      if (en_i && idx_i == IDX_W'(n)) rdata_o = hi_sel_i ? hi_i[n] : lo_i[n];
    end
  end
endmodule

// File: rtl/dbg_bkpt_bank.sv
module dbg_bkpt_bank
  import bpv_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] BASE     = 12'h400,
  parameter int unsigned       NUM_BP   = 16,
  parameter int unsigned       VA_MSB   = 52,
  parameter bit                KEEP_EXT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              core_pwr_i,
  input  logic              dlock_i,
  input  logic              oslock_i,
  input  logic              dbg_en_i,
  input  logic              sw_lock_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o
);
  acc_t                      acc;
  logic                      wr_hit;
  logic                      rd_hit;
  logic [NUM_BP-1:0]         wr_lo;
  logic [NUM_BP-1:0]         wr_hi;
  logic [NUM_BP-1:0][DW-1:0] slot_lo;
  logic [NUM_BP-1:0][DW-1:0] slot_hi;

  bpv_decode #(
    .ADDR_W(ADDR_W),
    .BASE  (BASE),
    .NUM_BP(NUM_BP)
  ) decode_i (
    .addr_i    (addr_i),
    .core_pwr_i(core_pwr_i),
    .dlock_i   (dlock_i),
    .oslock_i  (oslock_i),
    .dbg_en_i  (dbg_en_i),
    .acc_o     (acc)
  );

  assign wr_hit = req_i && wr_i && acc.claim && acc.open && acc.impl && !sw_lock_i;
  assign rd_hit = req_i && !wr_i && acc.claim && acc.open && acc.impl;
  assign err_o  = req_i && acc.claim && !acc.open;

  for (genvar n = 0; n < NUM_BP; n++) begin : g_slot
    assign wr_lo[n] = wr_hit && !acc.hi && (acc.idx == IDX_W'(n));
    assign wr_hi[n] = wr_hit &&  acc.hi && (acc.idx == IDX_W'(n));

    bpv_slot #(
      .VA_MSB  (VA_MSB),
      .KEEP_EXT(KEEP_EXT)
    ) slot_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_lo_i(wr_lo[n]),
      .wr_hi_i(wr_hi[n]),
      .wdata_i(wdata_i),
      .rd_lo_o(slot_lo[n]),
      .rd_hi_o(slot_hi[n])
    );
  end

  bpv_rdmux #(
    .NUM_BP(NUM_BP)
  ) rdmux_i (
    .lo_i    (slot_lo),
    .hi_i    (slot_hi),
    .en_i    (rd_hit),
    .hi_sel_i(acc.hi),
    .idx_i   (acc.idx),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/dbg_bkpt_bank_chk.sv
module dbg_bkpt_bank_chk #(
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] BASE     = 12'h400,
  parameter int unsigned       NUM_BP   = 16,
  parameter int unsigned       VA_MSB   = 52,
  parameter bit                KEEP_EXT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              core_pwr_i,
  input logic              dlock_i,
  input logic              oslock_i,
  input logic              dbg_en_i,
  input logic              sw_lock_i,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic [NUM_BP-1:0] wr_lo,
  input logic [NUM_BP-1:0] wr_hi
);
  localparam int unsigned HI_W  = VA_MSB - 31;
  localparam int unsigned EXT_W = 32 - HI_W;

  logic wr_any;
  logic stray;
  assign wr_any = |{wr_lo, wr_hi};
  assign stray  = (addr_i[ADDR_W-1:8] != BASE[ADDR_W-1:8]) || addr_i[3] || (addr_i[1:0] != 2'b00);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (!err_o && rdata_o == '0 && !wr_any)); // R1
  AST_STRAY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && stray) |-> (!err_o && rdata_o == '0 && !wr_any)); // R1
  AST_OPEN_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && core_pwr_i && !dlock_i && !oslock_i && dbg_en_i) |-> !err_o); // R2
  AST_WRITE_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wr_i) |-> (rdata_o == '0)); // R2
  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_lo, wr_hi})); // R10
  AST_LOCK_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_lock_i |-> !wr_any); // R3
  AST_ERR_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0 && !wr_any)); // R4
  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && 32'(addr_i[7:4]) >= NUM_BP) |-> (rdata_o == '0 && !wr_any)); // R5
  AST_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !addr_i[2]) |-> (rdata_o[1:0] == 2'b00)); // R6

  if (!KEEP_EXT) begin : g_mirror_chk
    AST_EXT_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && addr_i[2]) |-> (rdata_o[31:HI_W] == {EXT_W{rdata_o[HI_W-1]}})); // R8
  end
endmodule

bind dbg_bkpt_bank dbg_bkpt_bank_chk #(
  .ADDR_W  (ADDR_W),
  .BASE    (BASE),
  .NUM_BP  (NUM_BP),
  .VA_MSB  (VA_MSB),
  .KEEP_EXT(KEEP_EXT)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .core_pwr_i(core_pwr_i),
  .dlock_i   (dlock_i),
  .oslock_i  (oslock_i),
  .dbg_en_i  (dbg_en_i),
  .sw_lock_i (sw_lock_i),
  .rdata_o   (rdata_o),
  .err_o     (err_o),
  .wr_lo     (wr_lo),
  .wr_hi     (wr_hi)
);

// File: tb/dbg_bkpt_bank_tb_top.sv
module dbg_bkpt_bank_tb_top;
  localparam int NB = 5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        pwr = 1'b1, dlk = 1'b0, oslk = 1'b0, den = 1'b1, swl = 1'b0;
  logic [31:0] rd_s, rd_h;
  logic        err_s, err_h;

  int checks = 0;
  int errors = 0;

  // model: [0] stored extension, [1] mirrored extension
  logic [31:0] m_lo [2][16];
  logic [31:0] m_hi [2][16];

  always #10 clk = ~clk;

  dbg_bkpt_bank #(.NUM_BP(NB), .KEEP_EXT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .core_pwr_i(pwr), .dlock_i(dlk), .oslock_i(oslk), .dbg_en_i(den), .sw_lock_i(swl),
    .rdata_o(rd_s), .err_o(err_s));

  dbg_bkpt_bank #(.NUM_BP(NB), .KEEP_EXT(1'b0)) dut_hw_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .core_pwr_i(pwr), .dlock_i(dlk), .oslock_i(oslk), .dbg_en_i(den), .sw_lock_i(swl),
    .rdata_o(rd_h), .err_o(err_h));

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s addr=%h act=%h exp=%h", tag, what, addr, act, exp);
    end
  endtask

  // one request per clock: drive now, compare mid-cycle, commit at next edge
  task automatic op(input logic w, input logic [11:0] a, input logic [31:0] d, input string ovr = "");
    logic claim, open, impl;
    int   idx;
    logic [31:0] exp_rd;
    string tag;
    req = 1'b1; wr = w; addr = a; wdata = d;
    #9;
    claim = (a[11:8] == 4'h4) && !a[3] && (a[1:0] == 2'b00);
    open  = pwr && !dlk && !oslk && den;
    idx   = int'(a[7:4]);
    impl  = idx < NB;
    for (int k = 0; k < 2; k++) begin
      if (ovr != "")           tag = ovr;
      else if (!claim)         tag = "R1";
      else if (!open)          tag = "R4";
      else if (!impl)          tag = "R5";
      else if (w && swl)       tag = "R3";
      else if (w)              tag = "R2";
      else if (a[2])           tag = (k == 0) ? "R7" : "R8";
      else                     tag = "R6";
      exp_rd = (!w && claim && open && impl) ? (a[2] ? m_hi[k][idx] : m_lo[k][idx]) : 32'h0;
      cmp(tag, (k == 0) ? "rdata_st" : "rdata_hw", (k == 0) ? rd_s : rd_h, exp_rd);
      cmp(tag, (k == 0) ? "err_st" : "err_hw", {31'h0, (k == 0) ? err_s : err_h}, {31'h0, claim && !open});
    end
    if (w && claim && open && impl && !swl) begin
      if (a[2]) begin
        m_hi[0][idx] = d;
        m_hi[1][idx] = {{11{d[20]}}, d[20:0]};
      end else begin
        m_lo[0][idx] = d & 32'hFFFF_FFFC;
        m_lo[1][idx] = d & 32'hFFFF_FFFC;
      end
    end
    @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] slot(input int n, input bit hi);
    return 12'h400 + 12'(16 * n) + (hi ? 12'h4 : 12'h0);
  endfunction

  task automatic read_slot(input int n, input string ovr = "");
    op(1'b0, slot(n, 1'b0), 32'h0, ovr);
    op(1'b0, slot(n, 1'b1), 32'h0, ovr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    for (int k = 0; k < 2; k++) for (int n = 0; n < 16; n++) begin m_lo[k][n] = '0; m_hi[k][n] = '0; end
    repeat (3) @(posedge clk);
    // idle outputs while in reset
    #1; cmp("R1", "idle_rd", rd_s, 32'h0); cmp("R1", "idle_err", {31'h0, err_s}, 32'h0);
    rst_ni = 1'b1;
    @(posedge clk); #1;

    // R9: all zero after reset, including an unimplemented index
    for (int n = 0; n < NB; n++) read_slot(n, "R9");
    read_slot(15, "R9");

    // R2/R6/R7/R8: basic write and read back
    op(1'b1, slot(0, 0), 32'h1234_5677);
    op(1'b1, slot(0, 1), 32'hA5A5_A5A5);
    read_slot(0);
    op(1'b1, slot(1, 1), 32'h0010_0000);
    op(1'b0, slot(1, 1), 32'h0);
    op(1'b1, slot(1, 1), 32'hFFEF_FFFF);
    op(1'b0, slot(1, 1), 32'h0);
    op(1'b1, slot(NB - 1, 0), 32'hFFFF_FFFF);
    op(1'b1, slot(NB - 1, 1), 32'hFFFF_FFFF);
    read_slot(NB - 1);

    // R1: stray addresses must not alias into the bank
    op(1'b1, 12'h408, 32'hDEAD_BEEF);
    op(1'b1, 12'h40C, 32'hDEAD_BEEF);
    op(1'b1, 12'h401, 32'hDEAD_BEEF);
    op(1'b1, 12'h500, 32'hDEAD_BEEF);
    op(1'b1, 12'h3F0, 32'hDEAD_BEEF);
    op(1'b0, 12'h408, 32'h0);
    op(1'b0, 12'h406, 32'h0);
    read_slot(0, "R1");
    req = 1'b0; #9;
    cmp("R1", "noreq_rd", rd_s, 32'h0); cmp("R1", "noreq_err", {31'h0, err_h}, 32'h0);
    @(posedge clk); #1;

    // R10: half writes are independent
    op(1'b1, slot(2, 0), 32'h0F0F_0F0C, "R10");
    op(1'b1, slot(2, 1), 32'h7070_7070, "R10");
    op(1'b1, slot(2, 0), 32'h1111_2220, "R10");
    read_slot(2, "R10");
    read_slot(3, "R10");

    // R3: software lock makes the bank read-only
    swl = 1'b1;
    op(1'b1, slot(0, 0), 32'h0);
    op(1'b1, slot(0, 1), 32'h0);
    read_slot(0, "R3");
    swl = 1'b0;

    // R4: each failing condition alone
    for (int c = 0; c < 4; c++) begin
      pwr = (c != 0); dlk = (c == 1); oslk = (c == 2); den = (c != 3);
      op(1'b1, slot(2, 0), 32'hCAFE_F00C);
      op(1'b0, slot(2, 1), 32'h0);
      op(1'b0, slot(9, 0), 32'h0);
      op(1'b0, 12'h40C, 32'h0);
      pwr = 1'b1; dlk = 1'b0; oslk = 1'b0; den = 1'b1;
      read_slot(2, "R4");
    end

    // R5: unimplemented indices ignore writes and read zero
    op(1'b1, slot(NB, 0), 32'h5555_5555);
    op(1'b1, slot(9, 1), 32'h5555_5555);
    op(1'b1, slot(15, 0), 32'h5555_5555);
    read_slot(NB);
    read_slot(15);

    // mixed pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pwr  = !(lf[15:13] == 3'd0);
      dlk  =  (lf[15:13] == 3'd1);
      oslk =  (lf[15:13] == 3'd2) && lf[0];
      den  = !((lf[15:13] == 3'd3) && lf[1]);
      swl  =  (lf[12:11] == 2'd0);
      op(lf[9], {4'h4, lf[7:4], lf[3] & lf[8], lf[2], 2'b00}, {lf, ~lf ^ 16'(i)});
    end
    pwr = 1'b1; dlk = 1'b0; oslk = 1'b0; den = 1'b1; swl = 1'b0;
    for (int n = 0; n < NB; n++) read_slot(n);

    req = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule